// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC. It takes a byte-wide frame stream, marked with start and end flags, and checks the first six bytes of each frame. Those bytes are the destination MAC address. The block holds the whole frame in a local store and produces one accept or drop verdict per frame. Only accepted frames come out of the forwarding port. A dropped frame leaves no trace on that port.

Three control bits choose how the verdict is reached:
- **Promiscuous** accepts any frame.
- **Check-enable** turns address checking on. While it is off, every address counts as matching.
- **Compare-enable** selects what happens while checking is on. If it is set, the frame is compared against a programmed 48-bit station address. If it is clear, every frame counts as mismatching.

The control bits, the station address and two frame counters sit behind a small register port. Reads through that port have one cycle of latency. The block takes the mode and the address as a snapshot at start-of-frame, so software can rewrite them at any time without disturbing a frame already under way. The input stream is expected to be well formed: every start is followed by an end before the next start. Bytes may arrive back to back or with idle cycles between them.

Top module: `rx_daf`

## Requirements
- R1: Register offset 1 holds address bits 47:24 and offset 2 holds bits 23:0. The first byte received is compared with offset 1 bits 23:16, and the sixth byte with offset 2 bits 7:0. Both words reset to zero, are read/write in bits 23:0, and read zero in bits 31:24.
- R2: Register offset 0 is control: bit 31 is promiscuous, bit 30 is check-enable and bit 0 is compare-enable. All three reset to 0. Bits 29:1 read as zero whatever is written. Read data appears one cycle after the address is presented.
- R3: With promiscuous set, a frame of at least six bytes is accepted whatever its address and the other two bits.
- R4: With promiscuous clear and check-enable clear, a frame of at least six bytes is accepted whatever its address and compare-enable.
- R5: With promiscuous clear, check-enable set and compare-enable clear, every frame is dropped.
- R6: With promiscuous clear and both enables set, a frame is accepted only if all six destination bytes equal the programmed address.
- R7: A frame with fewer than six bytes is dropped in every mode. A frame of exactly six bytes is judged normally.
- R8: The mode bits and the station address are sampled on the start-of-frame byte. Register writes during a frame do not change that frame's verdict, but they do take effect from the next frame.
- R9: An accepted frame appears on the output port with every byte unchanged and in order: start flag on the first byte, end flag on the last. A dropped frame produces no output beats.
- R10: `frm_done` pulses for one cycle, in the cycle after the end-of-frame byte is taken. `frm_accept` gives the verdict in that same cycle.
- R11: A frame that does not fit in the frame store (2^BUF_AW bytes, counting bytes already waiting to be sent) is dropped.
- R12: Offset 3 counts accepted frames and offset 4 counts dropped frames. Both counters reset to zero and saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of forwarded frame |
| out_eof | output | 1 | Last byte of forwarded frame |
| frm_done | output | 1 | One-cycle verdict strobe |
| frm_accept | output | 1 | Verdict, valid with frm_done |

## Verification
The hardest case to reach is two frames arriving back to back, where the first is dropped and the second is kept. The drop rewinds the store's write pointer in the same cycle that the next frame's first byte is written. If that case is wrong, stale bytes leak out or the good frame is cut short. The bench reaches it by sending a mismatching frame and a matching frame with no idle cycle between them, then checking the number of output beats, their byte sum and the start/end flags. The second hard case is a register write in the middle of a frame. The bench reaches it by asserting the register write strobe in the same cycles as the fourth and fifth frame bytes, so the write lands after the snapshot but before the verdict.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_W     = DA_BYTES * 8;
  localparam int BCNT_W   = $clog2(DA_BYTES + 1);

  typedef struct packed {
    logic prom;  // accept all
    logic chk;   // address checking on
    logic cmp;   // compare against station address
  } mode_t;

  function automatic logic mode_accept(input mode_t m, input logic hit);
    if (m.prom)      return 1'b1;
    else if (!m.chk) return 1'b1;
    else if (!m.cmp) return 1'b0;
    else             return hit;
  endfunction
endpackage

// File: rtl/daf_regs.sv
module daf_regs
  import daf_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frm_done,
  input  logic              frm_accept,
  output mode_t             mode,
  output logic [DA_W-1:0]   station,
  output logic [CNT_W-1:0]  acc_cnt,
  output logic [CNT_W-1:0]  drp_cnt
);
  localparam int HALF_W = DA_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [HALF_W-1:0] st_hi, st_lo;
  logic [5:0]        unused_wbits;

  assign unused_wbits = reg_wdata[29:24];
  assign station      = {st_hi, st_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= '0;
      st_hi <= '0;
      st_lo <= '0;
    end else if (reg_wr) begin
      case (int'(reg_addr))
        0: mode  <= '{prom: reg_wdata[31], chk: reg_wdata[30], cmp: reg_wdata[0]};
        1: st_hi <= reg_wdata[HALF_W-1:0];
        2: st_lo <= reg_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      drp_cnt <= '0;
    end else if (frm_done) begin
      if (frm_accept && acc_cnt != CNT_MAX) acc_cnt <= acc_cnt + 1'b1;
      if (!frm_accept && drp_cnt != CNT_MAX) drp_cnt <= drp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (int'(reg_addr))
        0:       reg_rdata <= {mode.prom, mode.chk, 29'd0, mode.cmp};
        1:       reg_rdata <= 32'(st_hi);
        2:       reg_rdata <= 32'(st_lo);
        3:       reg_rdata <= 32'(acc_cnt);
        4:       reg_rdata <= 32'(drp_cnt);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  mode_t             mode_now,
  input  logic [DA_W-1:0]   station_now,
  output logic              dec_valid,
  output logic              dec_accept,
  output mode_t             mode_s,
  output logic [BCNT_W-1:0] byte_cnt
);
  localparam logic [BCNT_W-1:0] CNT_SAT = BCNT_W'(DA_BYTES);

  logic [DA_W-1:0]   addr_s, cur_addr;
  mode_t             cur_mode;
  logic              hit_q, base_hit, nxt_hit;
  logic [BCNT_W-1:0] base_cnt, nxt_cnt;
  logic [7:0]        want;

  always_comb begin
    cur_addr = in_sof ? station_now : addr_s;
    cur_mode = in_sof ? mode_now    : mode_s;
    base_cnt = in_sof ? '0          : byte_cnt;
    base_hit = in_sof ? 1'b1        : hit_q;
    want     = '0;
    for (int j = 0; j < DA_BYTES; j++)
      if (base_cnt == BCNT_W'(j)) want = cur_addr[8*(DA_BYTES-1-j) +: 8];
    nxt_hit = (base_cnt < CNT_SAT) ? (base_hit && in_data == want) : base_hit;
    nxt_cnt = (base_cnt == CNT_SAT) ? base_cnt : base_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt   <= '0;
      hit_q      <= 1'b0;
      mode_s     <= '0;
      addr_s     <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid <= in_valid && in_eof;
      if (in_valid) begin
        byte_cnt   <= nxt_cnt;
        hit_q      <= nxt_hit;
        dec_accept <= (nxt_cnt == CNT_SAT) && mode_accept(cur_mode, nxt_hit);
        if (in_sof) begin
          mode_s <= mode_now;
          addr_s <= station_now;
        end
      end
    end
  end
endmodule

// File: rtl/daf_fbuf.sv
module daf_fbuf #(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        commit,
  input  logic        discard,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        ovf,
  output logic [AW:0] fill
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int MW    = 10;

  logic [MW-1:0] mem [DEPTH];
  logic [MW-1:0] rd_q;
  logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr, wr_base, fill_w;
  logic          full, do_wr, rd_go;

  assign wr_base = discard ? cmt_ptr : wr_ptr;
  assign fill_w  = wr_base - rd_ptr;
  assign full    = (fill_w == PW'(DEPTH));
  assign do_wr   = in_valid && !full;
  assign rd_go   = (rd_ptr != cmt_ptr);
  assign fill    = wr_ptr - rd_ptr;

  always_ff @(posedge clk)
    if (do_wr) mem[wr_base[AW-1:0]] <= {in_sof, in_eof, in_data};

  always_ff @(posedge clk)
    rd_q <= mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      cmt_ptr   <= '0;
      rd_ptr    <= '0;
      ovf       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      wr_ptr    <= wr_base + PW'(do_wr);
      if (commit) cmt_ptr <= wr_ptr;
      if (in_valid && in_sof) ovf <= full;
      else if (in_valid && full) ovf <= 1'b1;
      out_valid <= rd_go;
      if (rd_go) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign out_sof  = rd_q[9];
  assign out_eof  = rd_q[8];
  assign out_data = rd_q[7:0];
endmodule

// File: rtl/rx_daf.sv
module rx_daf
  import daf_pkg::*;
#(
  parameter int BUF_AW = 6,
  parameter int CNT_W  = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              frm_done,
  output logic              frm_accept
);
  mode_t             mode_now, mode_s;
  logic [DA_W-1:0]   station;
  logic [CNT_W-1:0]  acc_cnt, drp_cnt;
  logic [BCNT_W-1:0] byte_cnt;
  logic              dec_valid, dec_accept, ovf;
  logic [BUF_AW:0]   fill;

  assign frm_done   = dec_valid;
  assign frm_accept = dec_accept && !ovf;

  daf_regs #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_done(frm_done), .frm_accept(frm_accept),
    .mode(mode_now), .station(station), .acc_cnt(acc_cnt), .drp_cnt(drp_cnt)
  );

  daf_match u_match (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .mode_now(mode_now),
    .station_now(station), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .mode_s(mode_s), .byte_cnt(byte_cnt)
  );

  daf_fbuf #(.AW(BUF_AW)) u_fbuf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .commit(frm_done && frm_accept), .discard(frm_done && !frm_accept),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .ovf(ovf), .fill(fill)
  );
endmodule

// File: rtl/rx_daf_chk.sv
module rx_daf_chk #(
  parameter int BUF_AW = 6,
  parameter int CNT_W  = 32,
  parameter int BCW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_done,
  input logic             frm_accept,
  input logic [2:0]       mode_s,
  input logic [BCW-1:0]   byte_cnt,
  input logic             ovf,
  input logic [BUF_AW:0]  fill,
  input logic [CNT_W-1:0] acc_cnt
);
  localparam logic [BUF_AW:0]  DEPTH   = (BUF_AW+1)'(1 << BUF_AW);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BCW-1:0]   FULL_DA = BCW'(6);

  // mode_s bits: [2] promiscuous, [1] check-enable, [0] compare-enable
  a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mode_s[2] && byte_cnt == FULL_DA && !ovf) |-> frm_accept);
  a_r4_nocheck_accepts: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mode_s[2:1] == 2'b00 && byte_cnt == FULL_DA && !ovf) |-> frm_accept);
  a_r5_reject_all: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mode_s == 3'b010) |-> !frm_accept);
  a_r7_short_drop: assert property (@(posedge clk) disable iff (rst)
    (frm_done && byte_cnt < FULL_DA) |-> !frm_accept);
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH);
  a_r11_ovf_drop: assert property (@(posedge clk) disable iff (rst)
    (frm_done && ovf) |-> !frm_accept);
  a_r12_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !(frm_done && frm_accept) |=> $stable(acc_cnt));
  a_r12_acc_sat: assert property (@(posedge clk) disable iff (rst)
    (acc_cnt == CNT_MAX) |=> (acc_cnt == CNT_MAX));
endmodule

bind rx_daf rx_daf_chk #(.BUF_AW(BUF_AW), .CNT_W(CNT_W), .BCW(daf_pkg::BCNT_W)) u_chk (
  .clk(clk), .rst(rst), .frm_done(frm_done), .frm_accept(frm_accept),
  .mode_s(mode_s), .byte_cnt(byte_cnt), .ovf(ovf), .fill(fill), .acc_cnt(acc_cnt)
);

// File: tb/rx_daf_bench.sv
`timescale 1ns/1ps
module rx_daf_bench;
  localparam int CW    = 3;
  localparam int CMAX  = (1 << CW) - 1;
  localparam logic [47:0] STA = 48'h0007ED_112233;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_sof, out_eof, frm_done, frm_accept;
  logic [7:0]  out_data;

  always #2 clk = ~clk;

  rx_daf #(.BUF_AW(6), .CNT_W(CW), .REG_AW(3)) u_rx_daf (.*);

  int n_chk = 0, n_err = 0, dec_cnt = 0, beats = 0, sofs = 0, eofs = 0;
  int e_acc = 0, e_drp = 0;
  logic [15:0] osum = '0;
  logic        last_acc = 1'b0, done_at_eof = 1'b0;
  bit          finished = 1'b0;

  // {mode[2:0] = prom,chk,cmp ; dest addr ; length ; expected verdict}
  localparam int NV = 13;
  localparam logic [59:0] VEC [NV] = '{
    {3'b000, 48'h0007ED_112233, 8'd12, 1'b1},  // R4
    {3'b000, 48'hFFFFFF_FFFFFF, 8'd10, 1'b1},  // R4
    {3'b010, 48'h0007ED_112233, 8'd12, 1'b0},  // R5
    {3'b011, 48'h0007ED_112233, 8'd9,  1'b1},  // R6
    {3'b011, 48'h0007ED_112234, 8'd9,  1'b0},  // R6 last byte differs
    {3'b011, 48'h0107ED_112233, 8'd9,  1'b0},  // R6 first byte differs
    {3'b011, 48'h112233_0007ED, 8'd9,  1'b0},  // R1 word order
    {3'b100, 48'hAAAAAA_AAAAAA, 8'd7,  1'b1},  // R3
    {3'b110, 48'h123456_789ABC, 8'd8,  1'b1},  // R3
    {3'b011, 48'h0007ED_112233, 8'd6,  1'b1},  // R7 exactly six
    {3'b011, 48'h0007ED_112233, 8'd5,  1'b0},  // R7 five bytes
    {3'b100, 48'h0007ED_112233, 8'd1,  1'b0},  // R7 one byte
    {3'b001, 48'h555555_555555, 8'd11, 1'b1}   // R4
  };
  localparam int VREQ [NV] = '{4, 4, 5, 6, 6, 6, 1, 3, 3, 7, 7, 7, 4};

  always @(negedge clk) begin
    if (out_valid) begin
      beats <= beats + 1;
      osum  <= osum + 16'(out_data);
      if (out_sof) sofs <= sofs + 1;
      if (out_eof) eofs <= eofs + 1;
    end
    if (frm_done) begin
      dec_cnt  <= dec_cnt + 1;
      last_acc <= frm_accept;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [2:0] m);
    return {m[2], m[1], 29'd0, m[0]};
  endfunction

  function automatic logic [7:0] fbyte(input logic [47:0] da, input int i);
    if (i < 6) return da[47-8*i -: 8];
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic logic [15:0] fsum(input logic [47:0] da, input int len);
    logic [15:0] s = '0;
    for (int i = 0; i < len; i++) s = s + 16'(fbyte(da, i));
    return s;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    if (e) done_at_eof = frm_done;
  endtask

  task automatic send_frame(input logic [47:0] da, input int len);
    for (int i = 0; i < len; i++) put(fbyte(da, i), i == 0, i == len - 1);
  endtask

  task automatic note(input bit acc);
    if (acc) e_acc++; else e_drp++;
  endtask

  task automatic run_frame(input logic [2:0] m, input logic [47:0] da, input int len,
                           input bit exp, input string req);
    int d0, b0, s0, f0;
    logic [15:0] u0;
    reg_write(3'd0, ctrl_word(m));
    d0 = dec_cnt; b0 = beats; s0 = sofs; f0 = eofs; u0 = osum;
    send_frame(da, len);
    check(done_at_eof === 1'b1, "R10 strobe after eof", 64'(done_at_eof), 1);
    repeat (len + 12) @(negedge clk);
    check(dec_cnt == d0 + 1, "R10 one verdict", 64'(dec_cnt - d0), 1);
    check(last_acc === exp, req, 64'(last_acc), 64'(exp));
    check(beats - b0 == (exp ? len : 0), "R9 beats", 64'(beats - b0), 64'(exp ? len : 0));
    check(osum - u0 == (exp ? fsum(da, len) : 16'd0), "R9 byte sum",
          64'(osum - u0), 64'(exp ? fsum(da, len) : 16'd0));
    check((sofs - s0 == int'(exp)) && (eofs - f0 == int'(exp)), "R9 frame flags",
          64'(sofs - s0), 64'(exp));
    note(exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    int d0, b0, s0;
    logic [15:0] u0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    reg_read(3'd0, rv); check(rv == 32'h0, "R2 ctrl reset", rv, 0);
    reg_read(3'd1, rv); check(rv == 32'h0, "R1 hi reset", rv, 0);
    reg_read(3'd2, rv); check(rv == 32'h0, "R1 lo reset", rv, 0);
    reg_read(3'd3, rv); check(rv == 32'h0, "R12 accept count reset", rv, 0);
    reg_read(3'd4, rv); check(rv == 32'h0, "R12 drop count reset", rv, 0);
    check(out_valid === 1'b0 && frm_done === 1'b0, "R9 idle outputs after reset",
          {out_valid, frm_done}, 0);

    // register field widths
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, rv); check(rv == 32'hC000_0001, "R2 reserved bits read zero", rv, 32'hC000_0001);
    reg_write(3'd1, 32'hFFFF_FFFF);
    reg_read(3'd1, rv); check(rv == 32'h00FF_FFFF, "R1 upper bits read zero", rv, 32'h00FF_FFFF);
    reg_write(3'd1, {8'h0, STA[47:24]});
    reg_write(3'd2, {8'hA5, STA[23:0]});
    reg_read(3'd1, rv); check(rv == 32'h0000_07ED, "R1 hi readback", rv, 32'h7ED);
    reg_read(3'd2, rv); check(rv == 32'h0011_2233, "R1 lo readback", rv, 32'h112233);

    // table-driven frames
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][59:57], VEC[v][56:9], int'(VEC[v][8:1]), VEC[v][0],
                $sformatf("R%0d verdict vector %0d", VREQ[v], v));

    reg_read(3'd3, rv); check(rv == 32'(e_acc), "R12 accept count", rv, e_acc);
    reg_read(3'd4, rv); check(rv == 32'(e_drp), "R12 drop count", rv, e_drp);

    // R8: mid-frame writes of mode and address leave this frame's verdict alone
    reg_write(3'd0, ctrl_word(3'b011));
    d0 = dec_cnt;
    for (int i = 0; i < 10; i++) begin
      if (i == 3) begin reg_addr = 3'd0; reg_wdata = ctrl_word(3'b010); reg_wr = 1'b1; end
      if (i == 4) begin reg_addr = 3'd1; reg_wdata = 32'h00AB_CDEF; reg_wr = 1'b1; end
      put(fbyte(STA, i), i == 0, i == 9);
      reg_wr = 1'b0;
    end
    repeat (20) @(negedge clk);
    check(dec_cnt == d0 + 1 && last_acc === 1'b1, "R8 snapshot at frame start", 64'(last_acc), 1);
    note(1'b1);
    reg_read(3'd0, rv); check(rv == 32'h4000_0000, "R8 write landed", rv, 32'h4000_0000);
    reg_write(3'd1, {8'h0, STA[47:24]});
    run_frame(3'b010, STA, 8, 1'b0, "R8 new mode on next frame");

    // back-to-back: dropped frame then accepted frame with no idle cycle
    reg_write(3'd0, ctrl_word(3'b011));
    d0 = dec_cnt; b0 = beats; s0 = sofs; u0 = osum;
    send_frame(48'h0007ED_000000, 8);
    send_frame(STA, 10);
    repeat (30) @(negedge clk);
    check(dec_cnt == d0 + 2, "R10 two verdicts", 64'(dec_cnt - d0), 2);
    check(beats - b0 == 10, "R9 back-to-back beats", 64'(beats - b0), 10);
    check(osum - u0 == fsum(STA, 10), "R9 back-to-back sum", 64'(osum - u0), 64'(fsum(STA, 10)));
    check(sofs - s0 == 1 && last_acc === 1'b1, "R6 back-to-back verdicts", 64'(sofs - s0), 1);
    note(1'b0); note(1'b1);

    // R11: frame longer than the store
    run_frame(3'b100, STA, 80, 1'b0, "R11 oversize frame dropped");
    run_frame(3'b100, STA, 20, 1'b1, "R11 store usable after overflow");

    // extra short frames drive the drop counter into saturation
    run_frame(3'b000, STA, 3, 1'b0, "R7 short frame");
    run_frame(3'b000, STA, 2, 1'b0, "R7 short frame");
    reg_read(3'd3, rv);
    check(rv == 32'((e_acc > CMAX) ? CMAX : e_acc), "R12 accept count saturates", rv, CMAX);
    reg_read(3'd4, rv);
    check(rv == 32'((e_drp > CMAX) ? CMAX : e_drp), "R12 drop count saturates", rv, CMAX);

    finish_run();
  end
endmodule